// File: doc/BRIEF.md
# Up-Counting Period Timer with Reset/Set Pulse Output

This block is a free-running timer that counts from zero up to a programmable limit. When it reaches that limit it returns to zero. One compare channel drives a pulse output in reset/set fashion. The output drops when the count reaches the compare value and rises again when the count rolls back to zero. Once loaded, the block produces a square or pulse-width-modulated waveform with no further action from a processor.

Software or surrounding logic drives the period limit and the compare threshold as plain parallel values. Changes to either value act on the very next clock. An enable freezes the timer, and a clear command restarts the cycle from zero. The live count and a one-clock rollover flag are brought out beside the pulse pin. The limit value L gives a cycle of L+1 clocks. With L=63 and a threshold of 32, the output is high for half of each cycle.

Top module: `upwm_timer`

## Requirements
- R1: While rst_n is low, and in the first cycle after it, count_o is 0, pwm_o is 0 and wrap_o is 0.
- R2: With en=1, clr=0 and period_val=L>0, count_o advances by one per clock while below L. From L it goes to 0, so one cycle lasts L+1 clocks and count_o never exceeds L.
- R3: wrap_o is 1 for exactly the one cycle in which count_o shows 0 after a rollover, and is 0 otherwise.
- R4: pwm_o goes to 0 in the same cycle that count_o takes a value equal to cmp_val.
- R5: pwm_o goes to 1 in the cycle count_o returns to 0 from a rollover. When cmp_val is 0, the compare reset takes priority and pwm_o stays 0.
- R6: When cmp_val is greater than period_val, pwm_o stays 1 through whole cycles. When cmp_val equals period_val, pwm_o is low for exactly one clock per cycle.
- R7: clr=1 sets count_o to 0 on the next clock whatever en is. It drives pwm_o to 1, or to 0 when cmp_val is 0, and keeps wrap_o at 0.
- R8: With en=0 and clr=0, count_o and pwm_o hold their values and wrap_o is 0.
- R9: With en=1, clr=0 and period_val=0, count_o is forced to 0 and held there, pwm_o holds, and wrap_o stays 0.
- R10: period_val and cmp_val act at once. If period_val is lowered to a value at or below the current count, the next enabled clock rolls the count to 0 with wrap_o set.
- R11: With period_val=63 and cmp_val=32, pwm_o is high for 32 of every 64 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Restart the count from zero |
| en | input | 1 | Count enable |
| period_val | input | W (16) | Count limit; the cycle lasts this value plus one clock |
| cmp_val | input | W (16) | Threshold at which the output is reset |
| pwm_o | output | 1 | Reset/set pulse output |
| count_o | output | W (16) | Current count |
| wrap_o | output | 1 | One-clock rollover flag |

## Verification
The bench targets the cases where the output edges meet or pass the cycle boundary. A threshold of zero tests the priority of reset over set; a design with set winning would give a one-clock glitch high at every rollover. A threshold above the limit tests a constant-high output, and a threshold equal to the limit tests a single low clock; an off-by-one in the compare timing would shift or lose that low clock. The limit is also lowered below the running count and then set to zero. A design that compared for equality only would run on to the top of the counter range, and one that ignored a zero limit would keep counting.

// File: rtl/upwm_pkg.sv
package upwm_pkg;

   // Per-clock action chosen by the counter and shared with the output stage
   typedef enum logic [2:0] {
      ACT_HOLD  = 3'd0,   // enable low: freeze everything
      ACT_STOP  = 3'd1,   // limit of zero: pin the count at zero
      ACT_CLEAR = 3'd2,   // restart command
      ACT_STEP  = 3'd3,   // ordinary increment
      ACT_WRAP  = 3'd4    // rollover from the limit to zero
   } tmr_act_e;

   function automatic logic act_moves(input tmr_act_e a);
      return (a == ACT_STEP) || (a == ACT_WRAP) || (a == ACT_CLEAR);
   endfunction

   function automatic logic act_restarts(input tmr_act_e a);
      return (a == ACT_WRAP) || (a == ACT_CLEAR);
   endfunction

endpackage

// File: rtl/upwm_counter.sv
module upwm_counter
   import upwm_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   input  logic [W-1:0] limit,
   output logic [W-1:0] cnt_q,
   output logic [W-1:0] cnt_next,
   output tmr_act_e     act,
   output logic         wrap_q
);

   localparam logic [W-1:0] ZERO = '0;
   localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

   logic at_limit;

   // Greater-or-equal so a limit lowered under the count still rolls over
   assign at_limit = (cnt_q >= limit);

   always_comb begin
      if (clr)                act = ACT_CLEAR;
      else if (!en)           act = ACT_HOLD;
      else if (limit == ZERO) act = ACT_STOP;
      else if (at_limit)      act = ACT_WRAP;
      else                    act = ACT_STEP;
   end

   always_comb begin
      unique case (act)
         ACT_STEP: cnt_next = cnt_q + ONE;
         ACT_HOLD: cnt_next = cnt_q;
         default:  cnt_next = ZERO;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= ZERO;
         wrap_q <= 1'b0;
      end else begin
         cnt_q  <= cnt_next;
         wrap_q <= (act == ACT_WRAP);
      end
   end

endmodule

// File: rtl/upwm_outstage.sv
module upwm_outstage
   import upwm_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  tmr_act_e     act,
   input  logic [W-1:0] cnt_next,
   input  logic [W-1:0] thresh,
   output logic         pin_q
);

   logic hit;
   logic pin_d;

   // Compared against the count being loaded, so the edge lines up with it
   assign hit = (cnt_next == thresh);

   always_comb begin
      pin_d = pin_q;
      if (act_moves(act)) begin
         if (hit)                    pin_d = 1'b0;   // reset wins
         else if (act_restarts(act)) pin_d = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_q <= 1'b0;
      else        pin_q <= pin_d;
   end

endmodule

// File: rtl/upwm_timer.sv
module upwm_timer
   import upwm_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   input  logic [W-1:0] period_val,
   input  logic [W-1:0] cmp_val,
   output logic         pwm_o,
   output logic [W-1:0] count_o,
   output logic         wrap_o
);

   generate
      if (W < 2 || W > 32) begin : g_bad_width
         $error("upwm_timer: W must lie in 2..32");
      end
   endgenerate

   tmr_act_e     act;
   logic [W-1:0] cnt_next;

   upwm_counter #(.W(W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .en       (en),
      .limit    (period_val),
      .cnt_q    (count_o),
      .cnt_next (cnt_next),
      .act      (act),
      .wrap_q   (wrap_o)
   );

   upwm_outstage #(.W(W)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .act      (act),
      .cnt_next (cnt_next),
      .thresh   (cmp_val),
      .pin_q    (pwm_o)
   );

endmodule

// File: rtl/upwm_timer_chk.sv
module upwm_timer_chk #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         clr,
   input logic         en,
   input logic [W-1:0] period_val,
   input logic [W-1:0] cmp_val,
   input logic         pwm_o,
   input logic [W-1:0] count_o,
   input logic         wrap_o
);

   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !clr && period_val != '0 && count_o < period_val)
      |=> (count_o == $past(count_o) + 1'b1) && !wrap_o);

   p_roll_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !clr && period_val != '0 && count_o >= period_val)
      |=> (count_o == '0) && wrap_o);

   p_flag_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_o |-> (count_o == '0));

   p_fall_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwm_o) |-> (count_o == $past(cmp_val)));

   p_rise_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwm_o) |-> (count_o == '0));

   p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (count_o == '0) && !wrap_o);

   p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !clr) |=> $stable(count_o) && $stable(pwm_o) && !wrap_o);

   p_stopped_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !clr && period_val == '0) |=> (count_o == '0) && $stable(pwm_o) && !wrap_o);

endmodule

bind upwm_timer upwm_timer_chk #(.W(W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .clr        (clr),
   .en         (en),
   .period_val (period_val),
   .cmp_val    (cmp_val),
   .pwm_o      (pwm_o),
   .count_o    (count_o),
   .wrap_o     (wrap_o)
);

// File: tb/sim_upwm_timer.sv
`timescale 1ns/1ps
module sim_upwm_timer;

   localparam int W = 16;
   // row: {clr, en, period, cmp, exp_count, exp_pwm, exp_wrap}
   localparam int NV = 30;
   localparam logic [51:0] VEC [0:NV-1] = '{
      {1'b1,1'b1,16'd3,16'd2, 16'd0,1'b1,1'b0},  // R7 clear
      {1'b0,1'b1,16'd3,16'd2, 16'd1,1'b1,1'b0},  // R2
      {1'b0,1'b1,16'd3,16'd2, 16'd2,1'b0,1'b0},  // R4 fall at match
      {1'b0,1'b1,16'd3,16'd2, 16'd3,1'b0,1'b0},
      {1'b0,1'b1,16'd3,16'd2, 16'd0,1'b1,1'b1},  // R3 R5 rollover
      {1'b0,1'b1,16'd3,16'd2, 16'd1,1'b1,1'b0},
      {1'b0,1'b0,16'd3,16'd2, 16'd1,1'b1,1'b0},  // R8 freeze
      {1'b0,1'b1,16'd3,16'd2, 16'd2,1'b0,1'b0},
      {1'b0,1'b1,16'd3,16'd2, 16'd3,1'b0,1'b0},
      {1'b0,1'b1,16'd3,16'd2, 16'd0,1'b1,1'b1},
      {1'b0,1'b1,16'd3,16'd5, 16'd1,1'b1,1'b0},  // R6 cmp above limit
      {1'b0,1'b1,16'd3,16'd5, 16'd2,1'b1,1'b0},
      {1'b0,1'b1,16'd3,16'd5, 16'd3,1'b1,1'b0},
      {1'b0,1'b1,16'd3,16'd5, 16'd0,1'b1,1'b1},
      {1'b0,1'b1,16'd3,16'd0, 16'd1,1'b1,1'b0},  // R5 cmp of zero
      {1'b0,1'b1,16'd3,16'd0, 16'd2,1'b1,1'b0},
      {1'b0,1'b1,16'd3,16'd0, 16'd3,1'b1,1'b0},
      {1'b0,1'b1,16'd3,16'd0, 16'd0,1'b0,1'b1},  // reset beats set
      {1'b0,1'b1,16'd3,16'd0, 16'd1,1'b0,1'b0},
      {1'b0,1'b1,16'd1,16'd0, 16'd0,1'b0,1'b1},  // R10 limit lowered to count
      {1'b0,1'b1,16'd0,16'd2, 16'd0,1'b0,1'b0},  // R9 stopped
      {1'b0,1'b1,16'd0,16'd2, 16'd0,1'b0,1'b0},
      {1'b1,1'b0,16'd3,16'd3, 16'd0,1'b1,1'b0},  // R7 clear with en low
      {1'b0,1'b1,16'd3,16'd3, 16'd1,1'b1,1'b0},
      {1'b0,1'b1,16'd3,16'd3, 16'd2,1'b1,1'b0},
      {1'b0,1'b1,16'd3,16'd3, 16'd3,1'b0,1'b0},  // R6 single low clock
      {1'b0,1'b1,16'd3,16'd3, 16'd0,1'b1,1'b1},
      {1'b0,1'b1,16'd3,16'd3, 16'd1,1'b1,1'b0},
      {1'b0,1'b1,16'd2,16'd3, 16'd2,1'b1,1'b0},  // R10 new limit
      {1'b0,1'b1,16'd2,16'd3, 16'd0,1'b1,1'b1}
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         clr = 1'b0;
   logic         en = 1'b0;
   logic [W-1:0] period_val = '0;
   logic [W-1:0] cmp_val = '0;
   logic         pwm_o;
   logic [W-1:0] count_o;
   logic         wrap_o;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   upwm_timer #(.W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .clr(clr), .en(en),
      .period_val(period_val), .cmp_val(cmp_val),
      .pwm_o(pwm_o), .count_o(count_o), .wrap_o(wrap_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic check_state(input string req, input int c, input bit p, input bit w);
      check(count_o == c, {req, " count"}, count_o, c);
      check(pwm_o == p,   {req, " pwm"},   pwm_o,   p);
      check(wrap_o == w,  {req, " wrap"},  wrap_o,  w);
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int high;
      int wraps;
      int maxc;
      // R1: state during reset
      repeat (3) @(negedge clk);
      check_state("R1 in reset", 0, 1'b0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check_state("R1 after reset", 0, 1'b0, 1'b0);

      // vector table: drive at negedge, check at next negedge
      for (int i = 0; i < NV; i++) begin
         clr        = VEC[i][51];
         en         = VEC[i][50];
         period_val = VEC[i][49:34];
         cmp_val    = VEC[i][33:18];
         @(negedge clk);
         check(count_o == VEC[i][17:2], $sformatf("R2 R10 row%0d count", i), count_o, VEC[i][17:2]);
         check(pwm_o == VEC[i][1],      $sformatf("R4 R5 R6 row%0d pwm", i), pwm_o, VEC[i][1]);
         check(wrap_o == VEC[i][0],     $sformatf("R3 row%0d wrap", i), wrap_o, VEC[i][0]);
      end

      // R11: half duty with limit 63, threshold 32
      clr = 1'b1; en = 1'b1; period_val = 16'd63; cmp_val = 16'd32;
      @(negedge clk);
      clr = 1'b0;
      high = 0; wraps = 0; maxc = 0;
      for (int k = 0; k < 128; k++) begin
         if (pwm_o) high++;
         if (wrap_o) wraps++;
         if (count_o > maxc) maxc = count_o;
         if (k == 31) check(pwm_o == 1'b1, "R11 last high clock", pwm_o, 1);
         if (k == 32) check(pwm_o == 1'b0, "R4 low at threshold", pwm_o, 0);
         @(negedge clk);
      end
      check(high == 64,  "R11 high clocks", high, 64);
      check(wraps == 1,  "R3 flags in 128 clocks", wraps, 1);
      check(maxc == 63,  "R2 peak count", maxc, 63);
      check_state("R2 cycle length", 0, 1'b1, 1'b1);

      // R9: limit dropped to zero mid-cycle
      repeat (5) @(negedge clk);
      period_val = '0;
      @(negedge clk);
      check_state("R9 forced zero", 0, 1'b1, 1'b0);
      repeat (3) @(negedge clk);
      check_state("R9 held", 0, 1'b1, 1'b0);

      // R1: reset while running
      period_val = 16'd63;
      repeat (40) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check_state("R1 mid-run reset", 0, 1'b0, 1'b0);
      rst_n = 1'b1;

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule